// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches a timer pin and, whenever an edge of the selected kind arrives, snapshots the running count into one of two capture slots. The first qualifying edge fills slot A and the second fills slot B. Once both slots are full, further edges are dropped until the unit is rearmed. A single-cycle event pulse goes to the interrupt logic. Depending on a select input, the pulse marks the first capture or the second, so software can timestamp one edge or measure the spacing between two.

The running count comes from a separate counter, and the pin level arrives already synchronised to the clock. The unit is rearmed, which empties the fill count but keeps the stored slot values, in two ways: a clear strobe from the status logic, or the capture mode moving from off to any active mode. Captures happen only while the direction input marks the pin as an input.

Top module: `dual_edge_capture`

## Requirements
- R1: The mode input selects the qualifying edge with the code 0 = off (no edge qualifies), 1 = rising, 2 = falling, 3 = both. An edge is found by comparing the pin level sampled at a clock edge with the level at the previous clock edge, and that stored level is low after reset.
- R2: No capture happens while `pin_is_input` is 0, even when a qualifying edge occurs.
- R3: The first accepted edge stores `count_in` into `cap_a` and the second stores it into `cap_b`. The stored value is the one present at the clock edge where the pin change is sampled, and it is visible after that edge.
- R4: When both slots have been filled, later qualifying edges leave both slots unchanged and raise no event until a rearm.
- R5: `cap_event` is high for exactly one cycle after the clock edge of a capture. With `second_sel` = 0 (sampled at that edge) it follows the capture into `cap_a`, and with `second_sel` = 1 it follows the capture into `cap_b`. No other capture raises it.
- R6: A cycle with `rearm_clr` = 1 returns the fill count to zero, so the next accepted edge goes to `cap_a`. The slot contents are kept.
- R7: A cycle where the mode is nonzero and the mode in the previous cycle was 0 (or the cycle is the first after reset) also returns the fill count to zero.
- R8: A qualifying edge in the same cycle as a rearm (R6 or R7) is dropped. The rearm wins.
- R9: During and after reset `cap_a`, `cap_b` and `cap_event` are 0, and the fill count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 1 | Synchronised pin level |
| pin_is_input | input | 1 | 1 = pin is an input, so capture is allowed |
| mode_sel | input | 2 | Edge mode: 0 off, 1 rising, 2 falling, 3 both |
| second_sel | input | 1 | 0 = event on first capture, 1 = event on second |
| rearm_clr | input | 1 | Rearm strobe from the status-clear logic |
| count_in | input | CNT_W | Live counter value |
| cap_a | output | CNT_W | First capture slot |
| cap_b | output | CNT_W | Second capture slot |
| cap_event | output | 1 | One-cycle capture event to interrupt logic |

## Verification
The bench drives falling edges while in rising mode to show that a wrong decode captures on the wrong polarity. It drives extra edges after both slots fill: a saturating count that wraps would overwrite `cap_a` with a later count. A rearm in the same cycle as an edge shows whether the design lets the edge through and fills `cap_a` early. The bench moves the mode off and back on to show a design that misses the off-to-active rearm. That design would put the next edge into `cap_b`. Edges with the pin set as an output, and the event placement under both settings of the select, find a design that captures while the pin is an output or pulses on the wrong slot.

// File: rtl/capt_pkg.sv
package capt_pkg;

  typedef enum logic [1:0] {
    CM_OFF  = 2'd0,
    CM_RISE = 2'd1,
    CM_FALL = 2'd2,
    CM_BOTH = 2'd3
  } cap_mode_e;

  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned FILL_W    = $clog2(NUM_SLOTS + 1);

endpackage

// File: rtl/capt_edge_qual.sv
module capt_edge_qual
  import capt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_lvl,
  input  logic      pin_is_input,
  input  cap_mode_e mode,
  output logic      hit
);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;
  logic edge_ok;

  // the previous level is tracked every cycle, whatever the mode
  always_comb begin
    prev_d = pin_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = pin_lvl & ~prev_q;
    fall = ~pin_lvl & prev_q;
    unique case (mode)
      CM_RISE: edge_ok = rise;
      CM_FALL: edge_ok = fall;
      CM_BOTH: edge_ok = rise | fall;
      default: edge_ok = 1'b0;
    endcase
    hit = edge_ok & pin_is_input;
  end

  // R1: in off mode no edge qualifies
  p_off_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_OFF) |-> !hit);

  // R1: a hit needs a level change since the last sample
  p_hit_needs_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pin_lvl != prev_q));

endmodule

// File: rtl/capt_seq.sv
module capt_seq
  import capt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  cap_mode_e            mode,
  input  logic                 rearm_clr,
  input  logic                 second_sel,
  output logic [NUM_SLOTS-1:0] wr_en,
  output logic                 event_q
);

  localparam logic [FILL_W-1:0] FULL = FILL_W'(NUM_SLOTS);

  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_d;
  cap_mode_e         mode_prev_q;
  cap_mode_e         mode_prev_d;
  logic              event_d;
  logic              arm_on_mode;
  logic              rearm;
  logic              accept;

  always_comb begin
    arm_on_mode = (mode_prev_q == CM_OFF) && (mode != CM_OFF);
    rearm       = rearm_clr | arm_on_mode;
    accept      = hit && !rearm && (fill_q < FULL);
    fill_d      = fill_q;
    if (rearm) begin
      fill_d = '0;
    end else if (accept) begin
      fill_d = fill_q + FILL_W'(1);
    end
    mode_prev_d = mode;
    event_d     = accept && (fill_q == FILL_W'(second_sel));
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_wr
    assign wr_en[i] = accept && (fill_q == FILL_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= '0;
      mode_prev_q <= CM_OFF;
      event_q     <= 1'b0;
    end else begin
      fill_q      <= fill_d;
      mode_prev_q <= mode_prev_d;
      event_q     <= event_d;
    end
  end

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == FULL && !rearm) |=> (fill_q == FULL));

  p_clear_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_clr |=> (fill_q == '0));

  p_mode_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_on_mode |=> (fill_q == '0));

  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  p_event_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> (fill_q == ($past(second_sel) ? FILL_W'(2) : FILL_W'(1))));

endmodule

// File: rtl/capt_slots.sv
module capt_slots
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            wr_en,
  input  logic [CNT_W-1:0]                count_in,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_q
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] val_d;

    always_comb begin
      val_d = wr_en[i] ? count_in : slot_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else begin
        slot_q[i] <= val_d;
      end
    end

    // R4: a slot only moves when its write enable was set
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |=> $stable(slot_q[i]));
  end

endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             pin_is_input,
  input  logic [1:0]       mode_sel,
  input  logic             second_sel,
  input  logic             rearm_clr,
  input  logic [CNT_W-1:0] count_in,
  output logic [CNT_W-1:0] cap_a,
  output logic [CNT_W-1:0] cap_b,
  output logic             cap_event
);

  cap_mode_e                       mode;
  logic                            hit;
  logic [NUM_SLOTS-1:0]            wr_en;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] slot_q;

  assign mode = cap_mode_e'(mode_sel);

  capt_edge_qual u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_lvl      (pin_lvl),
    .pin_is_input (pin_is_input),
    .mode         (mode),
    .hit          (hit)
  );

  capt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .mode       (mode),
    .rearm_clr  (rearm_clr),
    .second_sel (second_sel),
    .wr_en      (wr_en),
    .event_q    (cap_event)
  );

  capt_slots #(.CNT_W(CNT_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .count_in (count_in),
    .slot_q   (slot_q)
  );

  assign cap_a = slot_q[0];
  assign cap_b = slot_q[1];

  p_dir_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input |=> ($stable(cap_a) && $stable(cap_b) && !cap_event));

  p_rearm_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_clr |=> ($stable(cap_a) && $stable(cap_b) && !cap_event));

endmodule

// File: tb/dual_edge_capture_test.sv
module dual_edge_capture_test;

  localparam int unsigned W = 32;

  logic         clk;
  logic         rst_n;
  logic         pin_lvl;
  logic         pin_is_input;
  logic [1:0]   mode_sel;
  logic         second_sel;
  logic         rearm_clr;
  logic [W-1:0] count_in;
  logic [W-1:0] cap_a;
  logic [W-1:0] cap_b;
  logic         cap_event;

  int total;
  int bad;

  dual_edge_capture #(.CNT_W(W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_lvl      (pin_lvl),
    .pin_is_input (pin_is_input),
    .mode_sel     (mode_sel),
    .second_sel   (second_sel),
    .rearm_clr    (rearm_clr),
    .count_in     (count_in),
    .cap_a        (cap_a),
    .cap_b        (cap_b),
    .cap_event    (cap_event)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  typedef struct packed {
    logic         dir;
    logic [1:0]   mode;
    logic         sel;
    logic         pin;
    logic         clr;
    logic [W-1:0] cnt;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
    logic         ev;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    // R7: arm rising mode, no edge
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h10,  32'h0,   32'h0,   1'b0},
    // R3 R5: first rising edge into A, event (select 0)
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h20,  32'h20,  32'h0,   1'b1},
    // R1: falling edge ignored in rising mode
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h30,  32'h20,  32'h0,   1'b0},
    // R3: second rising edge into B, no event
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h40,  32'h20,  32'h40,  1'b0},
    // R4: edges after both slots filled are ignored
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h50,  32'h20,  32'h40,  1'b0},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h60,  32'h20,  32'h40,  1'b0},
    // R6: clear strobe rearms, slots kept
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 32'h70,  32'h20,  32'h40,  1'b0},
    // R1 R5: falling mode, select 1: first capture, no event
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 32'h80,  32'h80,  32'h40,  1'b0},
    '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 32'h90,  32'h80,  32'h40,  1'b0},
    // R5: second capture with select 1 raises event
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 32'hA0,  32'h80,  32'hA0,  1'b1},
    // R8: rearm together with an edge drops the edge
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 32'hB0,  32'h80,  32'hA0,  1'b0},
    // R1: both-edge mode, falling then rising
    '{1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'hC0,  32'hC0,  32'hA0,  1'b1},
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 32'hD0,  32'hC0,  32'hD0,  1'b0},
    // R2: pin as output, rearm then an edge that must be ignored
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 32'hE0,  32'hC0,  32'hD0,  1'b0},
    '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'hF0,  32'hC0,  32'hD0,  1'b0},
    // R6: input again, next edge lands in A
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 32'h100, 32'h100, 32'hD0,  1'b1},
    // R1: off mode ignores an edge
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 32'h110, 32'h100, 32'hD0,  1'b0},
    // R7: off to rising rearms the fill count
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h120, 32'h100, 32'hD0,  1'b0},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h130, 32'h130, 32'hD0,  1'b1},
    // R5: select 1 set before the second capture
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h140, 32'h130, 32'hD0,  1'b0},
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h150, 32'h130, 32'h150, 1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pin_is_input = v.dir;
    mode_sel     = v.mode;
    second_sel   = v.sel;
    pin_lvl      = v.pin;
    rearm_clr    = v.clr;
    count_in     = v.cnt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 cap_a in reset", cap_a, '0);
    chk("R9 cap_b in reset", cap_b, '0);
    chk("R9 event in reset", {31'b0, cap_event}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R3 cap_a vec %0d", i), cap_a, VEC[i].ea);
      chk($sformatf("R3 cap_b vec %0d", i), cap_b, VEC[i].eb);
      chk($sformatf("R5 event vec %0d", i), {31'b0, cap_event}, {31'b0, VEC[i].ev});
    end

    // R5: the event lasts one cycle only
    drive('{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h160, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    chk("R5 event single cycle", {31'b0, cap_event}, '0);

    // R9: reset in mid-run clears stored slots
    rst_n = 1'b0;
    #1ns;
    chk("R9 cap_a after reset", cap_a, '0);
    chk("R9 cap_b after reset", cap_b, '0);
    drive('0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: arm from off after reset, then one rising edge
    drive('{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h200, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    drive('{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 32'h210, 32'h0, 32'h0, 1'b0});
    @(negedge clk);
    chk("R7 capture after arm", cap_a, 32'h210);
    chk("R5 event after arm", {31'b0, cap_event}, 32'h1);
    chk("R9 cap_b still clear", cap_b, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule